// File: doc/BRIEF.md
# Parallel Port Nibble Reverse Reader

This block is the host side of the nibble reverse channel on a parallel port. It starts right after a successful mode negotiation. It receives bytes from the peripheral four bits at a time over five status lines, driving its own busy line as the handshake. Each pair of nibbles is assembled into a byte, and the byte is handed to the system on a valid/ready pair.

Software or a controller pulses `start` with the number of bytes it wants. The block then finishes with a one-cycle `done` pulse, a count of the bytes moved and an error flag. Between requests the block remembers where the link was left: just after negotiation, resting in reverse idle, in the middle of a transfer, or lost. Each request carries on from that point. A peripheral that runs out of data ends a request early, and this counts as success. Every wait on the peripheral has a timeout measured in clock cycles. All status inputs pass through a two-flop synchronizer before the state machine looks at them.

Top module: `nib_rev_rx`

## Requirements
- R1: After reset, host_busy, host_clk and select_in are 1, byte_valid and done are 0, and phase is 0. The phase codes are 0 post-negotiation, 1 reverse idle, 2 transfer and 3 lost.
- R2: If a request starts in phase 0 while data_avail_n (status bit 0) is high, the block waits at least SETTLE_CYC cycles. It then drives host_busy low, sets phase 1 and performs the idle check of R5.
- R3: If a request starts in phase 0 while data_avail_n is low, the block sets phase 2 and goes straight to nibble reception.
- R4: If a request starts in phase 1 while data_avail_n is low, host_busy is raised. The block then waits for the acknowledge line (status bit 2) to go low and moves to phase 2. If the acknowledge does not come within TMO_CYC cycles, the block sets error, term_ok=1 and phase 3.
- R5: If a request starts in phase 1 while data_avail_n is high, the block checks the lines. If acknowledge is 1 and the extension flag (status bit 1) is 0, the request succeeds with count 0, phase stays 1 and host_busy stays low. Any other combination sets error, term_ok=1 and phase 3.
- R6: Each nibble follows this handshake. The block drives host_busy low and waits for the peripheral clock (status bit 3) to go low. It latches the status and drives host_busy high, then waits for the peripheral clock to go high. A wait longer than TMO_CYC cycles sets error, term_ok=0 and phase 3.
- R7: A nibble is built as {~status[4], status[2], status[1], status[0]}. The first nibble of a byte is bits 3:0 and the second nibble is bits 7:4.
- R8: A received byte is presented with byte_valid=1. byte_data stays unchanged and byte_valid stays high until byte_ready is seen. done is never high while byte_valid is high.
- R9: After each accepted byte the block samples data_avail_n. If it is high, the request ends successfully with that byte counted, phase 1 and host_busy low. If it is low and the count equals the request, the request ends in phase 2.
- R10: A request made while phase is 3 ends at once with error=1, term_ok=0 and count 0.
- R11: done is a single-cycle pulse. xfer_count, error and term_ok keep their final values until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, accepted when no request is running |
| req_count | input | CNT_W | Number of bytes wanted (nonzero) |
| status_in | input | 5 | Peripheral lines: [4] busy, [3] peripheral clock, [2] acknowledge, [1] extension flag, [0] data_avail_n |
| host_busy | output | 1 | Host busy / acknowledge handshake line |
| host_clk | output | 1 | Host strobe line, held high in this mode |
| select_in | output | 1 | Mode select line, held high in this mode |
| byte_data | output | 8 | Assembled byte |
| byte_valid | output | 1 | byte_data is valid |
| byte_ready | input | 1 | Consumer accepts the byte |
| done | output | 1 | Request finished (one cycle) |
| xfer_count | output | CNT_W | Bytes moved by the last request |
| error | output | 1 | Last request failed |
| term_ok | output | 1 | After an error: the link may be shut down in an orderly way |
| phase | output | 2 | Link phase code (see R1) |

## Verification
The hardest situations to reach are those that depend on history. What a request does depends on the phase the previous request left behind. The early stop depends on the data-available level the peripheral shows only after the last nibble clock edge. The bench therefore chains its requests without resets between them: post-negotiation, then idle, then transfer, then an early stop, then lost. A reactive peripheral model changes data_avail_n together with the second nibble's clock edge. All 256 byte values go through one long request, and the consumer stalls the handshake partway through. Resets are used only to reach the timeout cases, where the peripheral model withholds one specific edge.

// File: rtl/nrr_pkg.sv
package nrr_pkg;
    typedef enum logic [1:0] {
        PH_NEGO = 2'd0,
        PH_IDLE = 2'd1,
        PH_XFER = 2'd2,
        PH_LOST = 2'd3
    } phase_e;

    typedef enum logic [2:0] {
        ST_WAIT,
        ST_SETTLE,
        ST_IDLE_CHK,
        ST_ACK_WAIT,
        ST_NIB_LO,
        ST_NIB_HI,
        ST_PUSH
    } st_e;

    localparam int SB_BUSY  = 4;
    localparam int SB_PCLK  = 3;
    localparam int SB_ACK   = 2;
    localparam int SB_XFLAG = 1;
    localparam int SB_DAVN  = 0;
    localparam int STAT_W   = 5;
    localparam logic [STAT_W-1:0] STAT_REST = 5'b11101;
endpackage

// File: rtl/nrr_sync.sv
module nrr_sync #(
    parameter int W = 5,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= RST;
            s2_q <= RST;
        end else begin
            s1_q <= d_in;
            s2_q <= s1_q;
        end
    end

    assign d_out = s2_q;
endmodule

// File: rtl/nrr_tick.sv
module nrr_tick #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic hit
);
    localparam int W = $clog2(LIMIT + 1);
    logic [W-1:0] c_d, c_q;

    assign hit = (c_q == W'(LIMIT - 1));

    always_comb begin
        c_d = c_q;
        if (clr)
            c_d = '0;
        else if (en && !hit)
            c_d = c_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end
endmodule

// File: rtl/nib_rev_rx.sv
module nib_rev_rx
    import nrr_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int TMO_CYC    = 2000,
    parameter int SETTLE_CYC = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] req_count,
    input  logic [4:0]       status_in,
    output logic             host_busy,
    output logic             host_clk,
    output logic             select_in,
    output logic [7:0]       byte_data,
    output logic             byte_valid,
    input  logic             byte_ready,
    output logic             done,
    output logic [CNT_W-1:0] xfer_count,
    output logic             error,
    output logic             term_ok,
    output logic [1:0]       phase
);
    typedef struct packed {
        st_e              st;
        phase_e           ph;
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] req;
        logic [3:0]       lo;
        logic             hi_half;
        logic [7:0]       dat;
        logic             vld;
        logic             done;
        logic             err;
        logic             tok;
    } regs_t;

    regs_t d, q;
    logic [STAT_W-1:0] s;
    logic [3:0]        nib;
    logic [CNT_W-1:0]  cnt_inc;
    logic              tmo_hit, tmo_en, tmo_clr;
    logic              settle_hit;

    nrr_sync #(.W(STAT_W), .RST(STAT_REST)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_in(status_in), .d_out(s)
    );

    assign tmo_en  = (q.st == ST_ACK_WAIT) || (q.st == ST_NIB_LO) || (q.st == ST_NIB_HI);
    assign tmo_clr = !tmo_en || (d.st != q.st);

    nrr_tick #(.LIMIT(TMO_CYC)) u_tmo (
        .clk(clk), .rst_n(rst_n), .clr(tmo_clr), .en(1'b1), .hit(tmo_hit)
    );

    nrr_tick #(.LIMIT(SETTLE_CYC)) u_settle (
        .clk(clk), .rst_n(rst_n), .clr(q.st != ST_SETTLE), .en(1'b1), .hit(settle_hit)
    );

    assign nib     = {~s[SB_BUSY], s[SB_ACK], s[SB_XFLAG], s[SB_DAVN]};
    assign cnt_inc = q.cnt + 1'b1;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            ST_WAIT: begin
                if (start) begin
                    d.req = req_count;
                    d.cnt = '0;
                    d.err = 1'b0;
                    d.tok = 1'b0;
                    unique case (q.ph)
                        PH_NEGO: begin
                            if (!s[SB_DAVN]) begin
                                d.ph      = PH_XFER;
                                d.busy    = 1'b0;
                                d.hi_half = 1'b0;
                                d.st      = ST_NIB_LO;
                            end else begin
                                d.st = ST_SETTLE;
                            end
                        end
                        PH_IDLE: d.st = ST_IDLE_CHK;
                        PH_XFER: begin
                            d.busy    = 1'b0;
                            d.hi_half = 1'b0;
                            d.st      = ST_NIB_LO;
                        end
                        default: begin
                            d.err  = 1'b1;
                            d.tok  = 1'b0;
                            d.ph   = PH_LOST;
                            d.done = 1'b1;
                        end
                    endcase
                end
            end
            ST_SETTLE: begin
                if (settle_hit) begin
                    d.busy = 1'b0;
                    d.ph   = PH_IDLE;
                    d.st   = ST_IDLE_CHK;
                end
            end
            ST_IDLE_CHK: begin
                if (!s[SB_DAVN]) begin
                    d.busy = 1'b1;
                    d.st   = ST_ACK_WAIT;
                end else if (s[SB_ACK] && !s[SB_XFLAG]) begin
                    d.done = 1'b1;
                    d.st   = ST_WAIT;
                end else begin
                    d.err  = 1'b1;
                    d.tok  = 1'b1;
                    d.ph   = PH_LOST;
                    d.done = 1'b1;
                    d.st   = ST_WAIT;
                end
            end
            ST_ACK_WAIT: begin
                if (!s[SB_ACK]) begin
                    d.ph      = PH_XFER;
                    d.busy    = 1'b0;
                    d.hi_half = 1'b0;
                    d.st      = ST_NIB_LO;
                end else if (tmo_hit) begin
                    d.err  = 1'b1;
                    d.tok  = 1'b1;
                    d.ph   = PH_LOST;
                    d.done = 1'b1;
                    d.st   = ST_WAIT;
                end
            end
            ST_NIB_LO: begin
                if (!s[SB_PCLK]) begin
                    if (q.hi_half) d.dat = {nib, q.lo};
                    else           d.lo  = nib;
                    d.busy = 1'b1;
                    d.st   = ST_NIB_HI;
                end else if (tmo_hit) begin
                    d.err  = 1'b1;
                    d.tok  = 1'b0;
                    d.ph   = PH_LOST;
                    d.done = 1'b1;
                    d.st   = ST_WAIT;
                end
            end
            ST_NIB_HI: begin
                if (s[SB_PCLK]) begin
                    if (q.hi_half) begin
                        d.vld = 1'b1;
                        d.st  = ST_PUSH;
                    end else begin
                        d.hi_half = 1'b1;
                        d.busy    = 1'b0;
                        d.st      = ST_NIB_LO;
                    end
                end else if (tmo_hit) begin
                    d.err  = 1'b1;
                    d.tok  = 1'b0;
                    d.ph   = PH_LOST;
                    d.done = 1'b1;
                    d.st   = ST_WAIT;
                end
            end
            ST_PUSH: begin
                if (byte_ready) begin
                    d.vld = 1'b0;
                    d.cnt = cnt_inc;
                    if (s[SB_DAVN]) begin
                        d.ph   = PH_IDLE;
                        d.busy = 1'b0;
                        d.done = 1'b1;
                        d.st   = ST_WAIT;
                    end else if (cnt_inc == q.req) begin
                        d.done = 1'b1;
                        d.st   = ST_WAIT;
                    end else begin
                        d.busy    = 1'b0;
                        d.hi_half = 1'b0;
                        d.st      = ST_NIB_LO;
                    end
                end
            end
            default: d.st = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.busy <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign host_busy  = q.busy;
    assign host_clk   = 1'b1;
    assign select_in  = 1'b1;
    assign byte_data  = q.dat;
    assign byte_valid = q.vld;
    assign done       = q.done;
    assign xfer_count = q.cnt;
    assign error      = q.err;
    assign term_ok    = q.tok;
    assign phase      = q.ph;
endmodule

// File: rtl/nrr_chk.sv
module nrr_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_busy,
    input logic [7:0]       byte_data,
    input logic             byte_valid,
    input logic             byte_ready,
    input logic             done,
    input logic             error,
    input logic [1:0]       phase,
    input logic [CNT_W-1:0] xfer_count
);
    p_valid_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid && !byte_ready |=> byte_valid && $stable(byte_data));

    p_no_done_while_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> !done);

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_count_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> $stable(xfer_count));

    p_error_lost_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done && error |-> phase == 2'd3);

    p_idle_busy_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done && !error && phase == 2'd1 |-> !host_busy);
endmodule

bind nib_rev_rx nrr_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .host_busy(host_busy), .byte_data(byte_data),
    .byte_valid(byte_valid), .byte_ready(byte_ready), .done(done),
    .error(error), .phase(phase), .xfer_count(xfer_count)
);

// File: tb/tb_nib_rev_rx.sv
`timescale 1ns/1ps
module tb_nib_rev_rx;
    localparam int CNT_W  = 9;
    localparam int TMO    = 24;
    localparam int SETTLE = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [CNT_W-1:0] req_count = '0;
    logic [4:0] stat = 5'b11101;
    logic host_busy, host_clk, select_in, byte_valid, done, error, term_ok;
    logic byte_ready = 1'b1;
    logic [7:0] byte_data;
    logic [CNT_W-1:0] xfer_count;
    logic [1:0] phase;

    int nchk = 0;
    int nfail = 0;
    int cycles = 0;
    logic [7:0] rxq [0:511];
    int rxn = 0;

    always #2.5 clk = ~clk;

    nib_rev_rx #(.CNT_W(CNT_W), .TMO_CYC(TMO), .SETTLE_CYC(SETTLE)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .req_count(req_count),
        .status_in(stat), .host_busy(host_busy), .host_clk(host_clk),
        .select_in(select_in), .byte_data(byte_data), .byte_valid(byte_valid),
        .byte_ready(byte_ready), .done(done), .xfer_count(xfer_count),
        .error(error), .term_ok(term_ok), .phase(phase)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            nfail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (byte_valid && byte_ready) begin
            rxq[rxn] = byte_data;
            rxn++;
        end
    end

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic do_reset(input logic [4:0] st);
        rst_n = 1'b0;
        stat = st;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic set_stat(input logic [4:0] st);
        stat = st;
        repeat (4) @(negedge clk);
    endtask

    task automatic req(input int n);
        @(negedge clk);
        start = 1'b1;
        req_count = CNT_W'(n);
        rxn = 0;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output int cyc);
        cyc = 0;
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic wait_busy(input logic v);
        int g = 0;
        while (host_busy !== v && g < 2000) begin
            @(negedge clk);
            g++;
        end
    endtask

    task automatic send_nib(input logic [3:0] n, input bit setdav, input logic dav);
        wait_busy(1'b0);
        repeat (2) @(negedge clk);
        stat = {~n[3], 1'b0, n[2:0]};
        wait_busy(1'b1);
        repeat (2) @(negedge clk);
        if (setdav) stat[0] = dav;
        stat[3] = 1'b1;
    endtask

    task automatic send_byte(input logic [7:0] b, input bit more);
        send_nib(b[3:0], 1'b0, 1'b0);
        send_nib(b[7:4], 1'b1, !more);
    endtask

    task automatic check_end(input string rq, input int cnt, input int err,
                             input int tok, input int ph);
        chk(xfer_count == CNT_W'(cnt), {rq, " count"}, int'(xfer_count), cnt);
        chk(error == err[0], {rq, " error"}, int'(error), err);
        if (err != 0) chk(term_ok == tok[0], {rq, " term_ok"}, int'(term_ok), tok);
        chk(phase == ph[1:0], {rq, " phase"}, int'(phase), ph);
    endtask

    initial begin
        int cyc;
        logic [7:0] held;

        do_reset(5'b11100);
        // R1 reset values
        chk(host_busy == 1'b1, "R1 host_busy", int'(host_busy), 1);
        chk(host_clk == 1'b1 && select_in == 1'b1, "R1 host_clk/select_in",
            int'({host_clk, select_in}), 3);
        chk(byte_valid == 1'b0, "R1 byte_valid", int'(byte_valid), 0);
        chk(done == 1'b0, "R1 done", int'(done), 0);
        chk(phase == 2'd0, "R1 phase", int'(phase), 0);

        // R3 post-negotiation with data: direct transfer, early stop R9, mapping R7
        fork
            req(4);
            send_byte(8'hA5, 1'b0);
        join
        wait_done(cyc);
        check_end("R3 R9 first byte", 1, 0, 0, 1);
        chk(rxq[0] == 8'hA5, "R7 first byte", int'(rxq[0]), 'hA5);
        chk(host_busy == 1'b0, "R9 busy low in idle", int'(host_busy), 0);
        @(negedge clk);
        chk(done == 1'b0, "R11 done pulse", int'(done), 0);
        chk(xfer_count == CNT_W'(1), "R11 count held", int'(xfer_count), 1);

        // R5 idle check passes
        set_stat(5'b11101);
        req(5);
        wait_done(cyc);
        check_end("R5 idle ok", 0, 0, 0, 1);
        chk(host_busy == 1'b0, "R5 busy stays low", int'(host_busy), 0);

        // R4 idle with data, stop on count reached
        set_stat(5'b11100);
        fork
            req(3);
            begin
                wait_busy(1'b1);
                repeat (2) @(negedge clk);
                stat[2] = 1'b0;
                send_byte(8'h3C, 1'b1);
                send_byte(8'hC3, 1'b1);
                send_byte(8'h7E, 1'b1);
            end
        join
        wait_done(cyc);
        check_end("R4 R9 idle to transfer", 3, 0, 0, 2);
        chk(rxq[0] == 8'h3C && rxq[1] == 8'hC3 && rxq[2] == 8'h7E, "R7 three bytes",
            int'(rxq[2]), 'h7E);

        // R7 exhaustive byte sweep in transfer phase with consumer stall R8
        fork
            req(256);
            for (int b = 0; b < 256; b++) send_byte(8'(b), 1'b1);
            begin
                while (rxn < 10) @(negedge clk);
                byte_ready = 1'b0;
                while (!byte_valid) @(negedge clk);
                held = byte_data;
                for (int k = 0; k < 4; k++) begin
                    @(negedge clk);
                    chk(byte_valid == 1'b1 && byte_data == held, "R8 held while stalled",
                        int'(byte_data), int'(held));
                end
                byte_ready = 1'b1;
            end
        join
        wait_done(cyc);
        check_end("R7 sweep", 256, 0, 0, 2);
        for (int b = 0; b < 256; b++)
            chk(rxq[b] == 8'(b), "R7 sweep byte", int'(rxq[b]), b);

        // R9 early stop from transfer
        fork
            req(4);
            begin
                send_byte(8'h5A, 1'b1);
                send_byte(8'h12, 1'b0);
            end
        join
        wait_done(cyc);
        check_end("R9 early stop", 2, 0, 0, 1);
        chk(host_busy == 1'b0, "R9 busy idle level", int'(host_busy), 0);

        // R5 idle validation failure (extension flag high)
        set_stat(5'b11111);
        req(2);
        wait_done(cyc);
        check_end("R5 idle mismatch", 0, 1, 1, 3);

        // R10 request while lost
        req(2);
        wait_done(cyc);
        check_end("R10 lost", 0, 1, 0, 3);
        @(negedge clk);
        chk(done == 1'b0 && error == 1'b1, "R11 error held", int'(error), 1);

        // R2 settle delay before idle
        do_reset(5'b11101);
        req(1);
        cyc = 0;
        while (host_busy && cyc < 1000) begin
            @(negedge clk);
            cyc++;
        end
        chk(cyc >= SETTLE, "R2 settle cycles", cyc, SETTLE);
        wait_done(cyc);
        check_end("R2 post-negotiation idle", 0, 0, 0, 1);

        // R4 acknowledge timeout
        set_stat(5'b11100);
        req(2);
        wait_done(cyc);
        check_end("R4 ack timeout", 0, 1, 1, 3);
        chk(cyc >= TMO, "R4 timeout length", cyc, TMO);

        // R6 timeout waiting for clock low
        do_reset(5'b11100);
        req(1);
        wait_done(cyc);
        check_end("R6 clock-low timeout", 0, 1, 0, 3);
        chk(cyc >= TMO, "R6 timeout length", cyc, TMO);

        // R6 timeout waiting for clock high
        do_reset(5'b11100);
        fork
            req(1);
            begin
                wait_busy(1'b0);
                repeat (2) @(negedge clk);
                stat[3] = 1'b0;
            end
        join
        wait_done(cyc);
        check_end("R6 clock-high timeout", 0, 1, 0, 3);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule